// File: doc/BRIEF.md
# Processor-side data bus sequencer

This block sits between a processor's bus unit and a 64-bit bidirectional data bus on a synchronous external bus. On this bus a cycle opens with a one-clock start strobe and each data beat closes when the system returns a ready strobe. For write cycles the block decides when the data pins are driven and what they carry. A single write drives one word. A burst writeback drives four words, taken in order from a line captured when the cycle starts. For read cycles it latches the bus on every ready strobe. When the final ready of a cycle arrives it raises a one-clock completion pulse.

The block also obeys the bus hand-off rules. A backoff request or a hold acknowledge floats the pins one clock later and suspends the cycle. The suspended cycle starts again from its first beat once both inputs fall. A processor reset or init request cancels the cycle outright. Byte enables select the meaningful byte lanes of single transfers and are disregarded for bursts. Address generation, arbitration, snooping and cache control sit outside the block.

Top module: `pbus_data_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `bus_oe`, `cyc_done` and `rd_valid` are 0 and `bus_out` is 0.
- R2: After a single write start is accepted, `bus_oe` is 1 from the next cycle through the cycle in which `rdy` is sampled, and 0 in the cycle after. `bus_out` lane n (bits 8n+7..8n) equals the same lane of line word 0 (`wr_line` bits 63..0) when `byte_en[n]` is 1, and 0 otherwise. During wait cycles the value is held.
- R3: For a burst write, `bus_oe` stays 1 from the cycle after the start through the cycle of the fourth ready. Beat k drives line word k (`wr_line` bits 64k+63..64k) on all eight lanes whatever `byte_en` holds. The data advances to the next word one clock after each earlier ready.
- R4: Each ready sampled during a read gives `rd_valid` = 1 in the next cycle, with `rd_data` holding the sampled bus. For single reads the lanes whose `byte_en` bit is 0 read as 0. For burst reads all lanes are kept.
- R5: `cyc_done` is a one-clock pulse in the cycle after the final ready of a cycle: the only ready of a single transfer, or the fourth ready of a burst. At no other time is it 1.
- R6: While `bkoff` or `hold_ack` is 1, `bus_oe` is 0 from the next clock and readies are ignored. One clock after both fall, the suspended cycle resumes at beat 0 and drives line word 0 again.
- R7: `cpu_reset` or `cpu_init` cancels any cycle. `bus_oe` is 0 from the next clock, readies are ignored, and the cycle does not resume.
- R8: A start strobe is ignored while a cycle is running or suspended, or while any of `bkoff`, `hold_ack`, `cpu_reset` or `cpu_init` is 1. An ignored start does not reload the line, the byte enables or the cycle kind.
- R9: `bus_oe` is never 1 during a read cycle, and `bus_out` is 0 whenever `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-clock cycle start strobe |
| cyc_wr | input | 1 | Cycle kind at start: 1 write, 0 read |
| cyc_burst | input | 1 | Cycle at start is a four-beat line burst |
| byte_en | input | 8 | Byte lane enables for single transfers |
| wr_line | input | 256 | Write line; word k in bits 64k+63..64k, captured at start |
| rdy | input | 1 | Ready strobe closing a data beat |
| bkoff | input | 1 | Backoff request: float and suspend |
| hold_ack | input | 1 | Hold acknowledge: float and suspend |
| cpu_reset | input | 1 | Processor reset: float and cancel |
| cpu_init | input | 1 | Processor init: float and cancel |
| bus_in | input | 64 | Data bus as seen at the pins |
| bus_oe | output | 1 | Tri-state enable for the data pins |
| bus_out | output | 64 | Value to drive on the data pins |
| rd_data | output | 64 | Read data captured at the last read ready |
| rd_valid | output | 1 | One-clock pulse: `rd_data` updated |
| cyc_done | output | 1 | One-clock pulse: cycle completed |

## Verification
`bus_oe` and `bus_out` are due one clock after an accepted start, a resume, or a backoff, hold, reset or init sample. `rd_valid`, `rd_data` and `cyc_done` are due one clock after the edge at which the ready is taken. The bench changes inputs on the falling edge and reads results on the next falling edge. Each result is therefore checked exactly one rising edge after the stimulus that caused it. Wait cycles, ignored readies and ignored starts are checked in the same way, one edge later, so a late or early change shows up as a wrong value at the sample point.

// File: rtl/pbds_pkg.sv
// Package: shared types for the data bus sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pbds_pkg;

    // Cycle controller states: no cycle, cycle moving data, cycle suspended.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HELD = 2'd2
    } seq_state_e;

endpackage

// File: rtl/pbds_lane_gate.sv
// Module: pbds_lane_gate
// Zeroes every byte lane of a word whose keep bit is 0.
// Assumes: lane n occupies bits 8n+7..8n.
module pbds_lane_gate #(
    parameter int LANES = 8
) (
    input  logic [LANES*8-1:0] din,
    input  logic [LANES-1:0]   keep,
    output logic [LANES*8-1:0] dout
);

    // One multiplexer per byte lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[8*i +: 8] = keep[i] ? din[8*i +: 8] : 8'h00;
    end

endmodule

// File: rtl/pbds_line_store.sv
// Module: pbds_line_store
// Holds the write line for one cycle, one register per beat word,
// and presents the word picked by the beat index.
// Assumes: load is a one-clock pulse at an accepted cycle start.
module pbds_line_store #(
    parameter int DATA_W = 64,
    parameter int BEATS  = 4,
    parameter int BEAT_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [DATA_W*BEATS-1:0]  line_in,
    input  logic [BEAT_W-1:0]        sel,
    output logic [DATA_W-1:0]        word
);

    logic [DATA_W-1:0] entry_q [BEATS];

    for (genvar k = 0; k < BEATS; k++) begin : g_entry
        // Capture word k of the line when a cycle is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[k] <= '0;
            end else if (load) begin
                entry_q[k] <= line_in[k*DATA_W +: DATA_W];
            end
        end
    end

    // Present the word for the current beat.
    always_comb begin
        word = entry_q[sel];
    end

endmodule

// File: rtl/pbds_beat_ctrl.sv
// Module: pbds_beat_ctrl
// Cycle state machine and beat counter. It accepts starts, counts
// readies, suspends on backoff/hold and cancels on reset/init.
// Assumes: suspend and cancel are already ORed by the caller.
module pbds_beat_ctrl
    import pbds_pkg::*;
#(
    parameter int BEATS  = 4,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_wr,
    input  logic              start_burst,
    input  logic              rdy,
    input  logic              suspend,
    input  logic              cancel,
    output logic              running,
    output logic              wr_q,
    output logic              burst_q,
    output logic              accept,
    output logic              xfer,
    output logic              last_xfer,
    output logic [BEAT_W-1:0] beat
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    seq_state_e        state_q, state_d;
    logic [BEAT_W-1:0] beat_q, beat_d;

    // Strobes decoded from the current state and the bus inputs.
    always_comb begin
        running   = (state_q == ST_RUN);
        accept    = start && (state_q == ST_IDLE) && !suspend && !cancel;
        xfer      = running && rdy && !suspend && !cancel;
        last_xfer = xfer && (!burst_q || (beat_q == LAST_BEAT));
        beat      = beat_q;
    end

    // Next state and beat index.
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        if (cancel) begin
            state_d = ST_IDLE;
            beat_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_d = ST_RUN;
                        beat_d  = '0;
                    end
                end
                ST_RUN: begin
                    if (suspend) begin
                        state_d = ST_HELD;
                        beat_d  = '0;
                    end else if (last_xfer) begin
                        state_d = ST_IDLE;
                        beat_d  = '0;
                    end else if (xfer) begin
                        beat_d  = beat_q + 1'b1;
                    end
                end
                ST_HELD: begin
                    if (!suspend) begin
                        state_d = ST_RUN;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    beat_d  = '0;
                end
            endcase
        end
    end

    // State, beat and cycle-kind registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            wr_q    <= 1'b0;
            burst_q <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            if (accept) begin
                wr_q    <= start_wr;
                burst_q <= start_burst;
            end
        end
    end

endmodule

// File: rtl/pbus_data_seq.sv
// Module: pbus_data_seq (top)
// Data bus sequencer for a start/ready synchronous bus. It drives write
// data with a tri-state enable, captures read data on each ready, and
// floats and suspends or cancels on backoff, hold, reset and init.
// Assumes: pins are resolved outside; bus_in is the pin value.
module pbus_data_seq #(
    parameter int DATA_W = 64,
    parameter int BEATS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cyc_start,
    input  logic                    cyc_wr,
    input  logic                    cyc_burst,
    input  logic [DATA_W/8-1:0]     byte_en,
    input  logic [DATA_W*BEATS-1:0] wr_line,
    input  logic                    rdy,
    input  logic                    bkoff,
    input  logic                    hold_ack,
    input  logic                    cpu_reset,
    input  logic                    cpu_init,
    input  logic [DATA_W-1:0]       bus_in,
    output logic                    bus_oe,
    output logic [DATA_W-1:0]       bus_out,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    rd_valid,
    output logic                    cyc_done
);

    localparam int LANES  = DATA_W / 8;
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic              running, wr_q, burst_q, accept, xfer, last_xfer;
    logic [BEAT_W-1:0] beat;
    logic [LANES-1:0]  be_q, lane_keep;
    logic [DATA_W-1:0] line_word, wr_gated, rd_gated;
    logic              suspend, cancel;

    // Group the hand-off inputs.
    always_comb begin
        suspend = bkoff || hold_ack;
        cancel  = cpu_reset || cpu_init;
    end

    pbds_beat_ctrl #(.BEATS(BEATS), .BEAT_W(BEAT_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(cyc_start), .start_wr(cyc_wr),
        .start_burst(cyc_burst), .rdy(rdy), .suspend(suspend),
        .cancel(cancel), .running(running), .wr_q(wr_q),
        .burst_q(burst_q), .accept(accept), .xfer(xfer),
        .last_xfer(last_xfer), .beat(beat)
    );

    pbds_line_store #(.DATA_W(DATA_W), .BEATS(BEATS), .BEAT_W(BEAT_W)) line_i (
        .clk(clk), .rst_n(rst_n), .load(accept), .line_in(wr_line),
        .sel(beat), .word(line_word)
    );

    // Keep the byte enables of the accepted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            be_q <= '0;
        end else if (accept) begin
            be_q <= byte_en;
        end
    end

    // Bursts use every lane; single transfers use the enabled lanes.
    always_comb begin
        lane_keep = burst_q ? '1 : be_q;
    end

    pbds_lane_gate #(.LANES(LANES)) wr_gate_i (
        .din(line_word), .keep(lane_keep), .dout(wr_gated)
    );

    pbds_lane_gate #(.LANES(LANES)) rd_gate_i (
        .din(bus_in), .keep(lane_keep), .dout(rd_gated)
    );

    // Pin drive: only while a write cycle is running.
    always_comb begin
        bus_oe  = running && wr_q;
        bus_out = bus_oe ? wr_gated : '0;
    end

    // Read capture and completion pulses, one clock after the ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            cyc_done <= 1'b0;
        end else begin
            rd_valid <= xfer && !wr_q;
            cyc_done <= last_xfer;
            if (xfer && !wr_q) begin
                rd_data <= rd_gated;
            end
        end
    end

endmodule

// File: rtl/pbds_chk.sv
// Module: pbds_chk
// Protocol checker bound to pbus_data_seq; it watches the ports only.
// Assumes: sampled on the rising clock edge.
module pbds_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rdy,
    input logic              bkoff,
    input logic              hold_ack,
    input logic              cpu_reset,
    input logic              cpu_init,
    input logic              bus_oe,
    input logic [DATA_W-1:0] bus_out,
    input logic              rd_valid,
    input logic              cyc_done
);

    // Outputs are quiet right after reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !bus_oe && !cyc_done && !rd_valid);

    // Drive holds steady across wait cycles.
    assert_wait_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe && !rdy && !bkoff && !hold_ack && !cpu_reset && !cpu_init
        |=> bus_oe && $stable(bus_out));

    // Completion is a single-clock pulse.
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

    // Backoff or hold floats the pins and blocks transfers next clock.
    assert_float_on_suspend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bkoff || hold_ack) |=> !bus_oe && !rd_valid && !cyc_done);

    // Reset or init floats the pins and blocks transfers next clock.
    assert_float_on_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_reset || cpu_init) |=> !bus_oe && !rd_valid && !cyc_done);

    // Read captures never coincide with driving; idle pins carry zero.
    assert_read_undriven_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !bus_oe);

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));

endmodule

bind pbus_data_seq pbds_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .rdy(rdy), .bkoff(bkoff),
    .hold_ack(hold_ack), .cpu_reset(cpu_reset), .cpu_init(cpu_init),
    .bus_oe(bus_oe), .bus_out(bus_out), .rd_valid(rd_valid),
    .cyc_done(cyc_done)
);

// File: tb/pbus_data_seq_tb_top.sv
// Bench for pbus_data_seq: a vector table walked by one loop, then
// directed tests for reset, suspend, cancel and ignored starts.
module pbus_data_seq_tb_top;

    logic         clk = 1'b0;
    logic         rst_n, cyc_start, cyc_wr, cyc_burst, rdy;
    logic         bkoff, hold_ack, cpu_reset, cpu_init;
    logic [7:0]   byte_en;
    logic [255:0] wr_line;
    logic [63:0]  bus_in, bus_out, rd_data;
    logic         bus_oe, rd_valid, cyc_done;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    pbus_data_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_wr(cyc_wr),
        .cyc_burst(cyc_burst), .byte_en(byte_en), .wr_line(wr_line),
        .rdy(rdy), .bkoff(bkoff), .hold_ack(hold_ack),
        .cpu_reset(cpu_reset), .cpu_init(cpu_init), .bus_in(bus_in),
        .bus_oe(bus_oe), .bus_out(bus_out), .rd_data(rd_data),
        .rd_valid(rd_valid), .cyc_done(cyc_done)
    );

    // Vector fields: [11] write, [10] burst, [9:8] wait cycles, [7:0] enables.
    localparam logic [11:0] VEC [8] = '{
        12'b1_0_00_11111111, 12'b1_0_01_00001111, 12'b1_0_00_10100101,
        12'b1_1_00_00000000, 12'b1_1_10_00111100, 12'b0_0_00_11110000,
        12'b0_0_01_10000001, 12'b0_1_00_00000001
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] lane_mask(input logic burst, input logic [7:0] be);
        logic [63:0] m = '0;
        for (int i = 0; i < 8; i++) if (burst || be[i]) m[8*i +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [63:0] line_word(input int seed, input int k);
        return {8'(seed), 8'(k), 16'hC0DE, 8'(seed * 3 + 1), 8'(k * 17 + 5), 16'h1E5A};
    endfunction

    function automatic logic [255:0] make_line(input int seed);
        logic [255:0] l;
        for (int k = 0; k < 4; k++) l[64*k +: 64] = line_word(seed, k);
        return l;
    endfunction

    function automatic logic [63:0] rd_pat(input int seed, input int b);
        return {16'hBEEF, 8'(seed), 8'(b), 32'h0F1E2D3C ^ 32'(seed * b + 7)};
    endfunction

    task automatic start_cyc(input int seed, input logic wr, input logic burst,
                             input logic [7:0] be);
        @(negedge clk);
        wr_line = make_line(seed); cyc_start = 1; cyc_wr = wr;
        cyc_burst = burst; byte_en = be;
        @(negedge clk);
        cyc_start = 0; wr_line = ~wr_line; byte_en = ~be;
    endtask

    // One beat from the current falling edge: check drive, pulse ready.
    task automatic do_beat(input string req, input int seed, input int b, input logic wr,
                           input logic [63:0] m, input logic last);
        chk(wr ? req : "R9", bus_oe, wr);
        if (wr) chk(req, bus_out, line_word(seed, b) & m);
        else bus_in = rd_pat(seed, b);
        rdy = 1;
        @(negedge clk);
        rdy = 0;
        if (!wr) begin
            chk("R4", rd_valid, 1);
            chk("R4", rd_data, rd_pat(seed, b) & m);
        end
        chk("R5", cyc_done, last);
    endtask

    task automatic run_cycle(input int seed, input logic wr, input logic burst,
                             input int waits, input logic [7:0] be);
        logic [63:0] m = lane_mask(burst, be);
        int          nb = burst ? 4 : 1;
        string       req = burst ? "R3" : "R2";
        start_cyc(seed, wr, burst, be);
        for (int b = 0; b < nb; b++) begin
            for (int w = 0; w < waits; w++) begin
                chk(req, bus_oe, wr);
                chk(req, bus_out, wr ? (line_word(seed, b) & m) : 64'h0);
                @(negedge clk);
            end
            do_beat(req, seed, b, wr, m, b == nb - 1);
        end
        chk(req, bus_oe, 0);
        @(negedge clk);
        chk("R5", cyc_done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cyc_start = 0; cyc_wr = 0; cyc_burst = 0; rdy = 0;
        bkoff = 0; hold_ack = 0; cpu_reset = 0; cpu_init = 0;
        byte_en = 0; wr_line = '0; bus_in = '0;

        // R1: reset state, with a start held during reset.
        cyc_start = 1; cyc_wr = 1;
        repeat (2) @(negedge clk);
        chk("R1", bus_oe, 0); chk("R1", cyc_done, 0);
        chk("R1", rd_valid, 0); chk("R1", bus_out, 0);
        cyc_start = 0; rst_n = 1;
        @(negedge clk);
        chk("R1", bus_oe, 0); chk("R1", rd_data, 0);

        // Table of cycle kinds, enables and wait states (R2, R3, R4, R5, R9).
        for (int i = 0; i < 8; i++) begin
            run_cycle(i + 10, VEC[i][11], VEC[i][10], int'(VEC[i][9:8]), VEC[i][7:0]);
        end

        // R6: backoff in a burst write, with a ready ignored, then restart.
        start_cyc(40, 1, 1, 8'h00);
        do_beat("R3", 40, 0, 1, '1, 0);
        do_beat("R3", 40, 1, 1, '1, 0);
        bkoff = 1; rdy = 1;
        @(negedge clk);
        chk("R6", bus_oe, 0); chk("R6", cyc_done, 0);
        @(negedge clk);
        chk("R6", bus_oe, 0); chk("R6", cyc_done, 0);
        bkoff = 0; rdy = 0;
        @(negedge clk);
        chk("R6", bus_oe, 1); chk("R6", bus_out, line_word(40, 0));
        for (int b = 0; b < 4; b++) do_beat("R6", 40, b, 1, '1, b == 3);
        chk("R6", bus_oe, 0);

        // R6: hold acknowledge in a burst read; restart needs four readies.
        start_cyc(41, 0, 1, 8'h00);
        do_beat("R6", 41, 0, 0, '1, 0);
        hold_ack = 1; rdy = 1;
        @(negedge clk);
        chk("R6", rd_valid, 0);
        hold_ack = 0; rdy = 0;
        @(negedge clk);
        for (int b = 0; b < 4; b++) do_beat("R6", 41, b, 0, '1, b == 3);

        // R7: init cancels a single write; no resume, ready ignored.
        start_cyc(42, 1, 0, 8'hFF);
        chk("R7", bus_oe, 1);
        cpu_init = 1;
        @(negedge clk);
        chk("R7", bus_oe, 0);
        cpu_init = 0;
        repeat (3) @(negedge clk);
        chk("R7", bus_oe, 0);
        rdy = 1;
        @(negedge clk);
        rdy = 0;
        chk("R7", cyc_done, 0);

        // R7: reset input cancels a burst read.
        start_cyc(43, 0, 1, 8'h00);
        cpu_reset = 1; rdy = 1; bus_in = 64'h1234;
        @(negedge clk);
        chk("R7", rd_valid, 0); chk("R7", cyc_done, 0);
        cpu_reset = 0; rdy = 0;
        @(negedge clk);
        chk("R7", bus_oe, 0);

        // R8: a start during a running burst is ignored.
        start_cyc(44, 1, 1, 8'h00);
        do_beat("R8", 44, 0, 1, '1, 0);
        wr_line = make_line(99); cyc_start = 1; cyc_wr = 0; byte_en = 8'h01;
        do_beat("R8", 44, 1, 1, '1, 0);
        cyc_start = 0;
        do_beat("R8", 44, 2, 1, '1, 0);
        do_beat("R8", 44, 3, 1, '1, 1);
        chk("R8", bus_oe, 0);

        // R8: a start while backoff is high is ignored.
        bkoff = 1; cyc_start = 1; cyc_wr = 1; cyc_burst = 0;
        @(negedge clk);
        bkoff = 0; cyc_start = 0;
        @(negedge clk);
        chk("R8", bus_oe, 0);
        rdy = 1;
        @(negedge clk);
        rdy = 0;
        chk("R8", cyc_done, 0);

        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule